// File: doc/BRIEF.md
# Double-Data-Rate Strobe Data Path

This block sits between a memory controller's core logic and the pins of a double-data-rate memory. On a write, it takes one internal word of twice the pin width per core clock. The lower half goes out while the core clock is high and the upper half while it is low. A strobe is generated from a quarter-period-shifted copy of the clock, so each strobe edge lands in the middle of a data beat. A write burst always starts with one preamble cycle, in which the pins are driven and the strobe is held low.

On a read, the memory drives the strobe with its edges aligned to the data transitions. The board or pad logic delays the strobe so that it samples inside the eye. The block captures one beat on each strobe edge, pairs the rising and falling beats into a full word, and passes the words into the core clock domain through a small gray-pointer queue. Each reassembled word is reported with a one-cycle valid pulse.

The output enables of the data and strobe pins are high only from the preamble to the last write beat. Outside that window the shared pins are free for the memory to drive.

Top module: `ddr_strobe_path`

## Requirements
- R1: While `rst_ni` is low and after its release with no stimulus, `dq_oe_o`, `dqs_oe_o`, `dqs_o`, `wr_busy_o`, `wr_take_o` and `rd_valid_o` are 0 and `dq_o` is all zeros.
- R2: `wr_bl_i` selects the write burst length in beats: 2'b00 gives 2, 2'b01 gives 4, and 2'b10 or 2'b11 gives 8. A burst takes beats/2 words, and `wr_take_o` is high in each cycle whose closing clock edge samples `wr_data_i`.
- R3: In the cycle after `wr_start_i` is sampled while idle, both output enables are 1, `wr_take_o` is 1, and `dqs_o` and `dq_o` stay 0 for the whole cycle (the preamble).
- R4: In each data cycle, `dq_o` carries bits [n-1:0] of the current word while `clk_i` is high and bits [2n-1:n] while it is low.
- R5: In each data cycle, `dqs_o` follows `clk90_i`, rising a quarter period after the core rising edge and falling a quarter period after the falling edge.
- R6: Both output enables fall in the cycle after the last data word, and `wr_busy_o` falls with them.
- R7: `wr_start_i` has no effect while `wr_busy_o` is high. The running burst keeps its length and its data, and no new burst starts on its own.
- R8: On reads, the beat sampled on a rising `dqs_i` edge becomes bits [n-1:0] of a word and the beat on the next falling edge becomes bits [2n-1:n]. The word appears on `rd_data_o` with `rd_valid_o` high for one core cycle.
- R9: A continuous read stream of one word per clock period is delivered without loss, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| clk90_i | input | 1 | Core clock delayed by a quarter period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Start a write burst (sampled while idle) |
| wr_bl_i | input | 2 | Burst length code |
| wr_data_i | input | 2*DQ_W | Write word, sampled when wr_take_o is high |
| wr_take_o | output | 1 | The closing edge of this cycle samples wr_data_i |
| wr_busy_o | output | 1 | Write burst in progress |
| dq_o | output | DQ_W | Data pin output value |
| dq_oe_o | output | 1 | Data pin output enable |
| dqs_o | output | 1 | Strobe pin output value |
| dqs_oe_o | output | 1 | Strobe pin output enable |
| dq_i | input | DQ_W | Data pin input value |
| dqs_i | input | 1 | Strobe pin input value (already delayed into the eye) |
| rd_data_o | output | 2*DQ_W | Reassembled read word |
| rd_valid_o | output | 1 | One-cycle pulse per read word |

## Verification
The hardest case to reach is a read stream with no gaps. The strobe domain then writes a word every period while the core side is still synchronizing the earlier pointers, so the queue sits close to its deepest fill. The bench sends bursts of up to eight back-to-back words, with their strobe edges offset from the core edges. It checks that every word arrives once and in order. For write bursts, the bench holds `wr_start_i` high through the data cycles with a different length code, and checks at the pins that the beat count and the release cycle stay unchanged.

// File: rtl/ddr_path_pkg.sv
package ddr_path_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_PRE  = 2'd1,
    WS_DATA = 2'd2
  } wr_state_e;

  // burst length code -> number of 2n-bit words
  function automatic logic [2:0] burst_words(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq
  import ddr_path_pkg::*;
#(
  parameter int unsigned DQ_W = 8,
  localparam int unsigned WORD_W = 2 * DQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        bl_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              pre_o,
  output logic              data_o,
  output logic              take_o,
  output logic              busy_o
);
  wr_state_e         st_q;
  logic [2:0]        left_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WS_IDLE;
      left_q <= '0;
      word_q <= '0;
    end else begin
      case (st_q)
        WS_IDLE: if (start_i) begin
          st_q   <= WS_PRE;
          left_q <= burst_words(bl_i);
        end
        WS_PRE: begin
          st_q   <= WS_DATA;
          word_q <= data_i;
          left_q <= left_q - 3'd1;
        end
        WS_DATA: begin
          if (left_q == '0) begin
            st_q <= WS_IDLE;
          end else begin
            word_q <= data_i;
            left_q <= left_q - 3'd1;
          end
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  assign word_o = word_q;
  assign pre_o  = (st_q == WS_PRE);
  assign data_o = (st_q == WS_DATA);
  assign take_o = pre_o || (data_o && left_q != '0);
  assign busy_o = (st_q != WS_IDLE);
endmodule

// File: rtl/ddr_tx_mux.sv
module ddr_tx_mux #(
  parameter int unsigned DQ_W = 8,
  localparam int unsigned WORD_W = 2 * DQ_W
) (
  input  logic              clk_i,
  input  logic              clk90_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              pre_i,
  input  logic              data_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              dqs_o,
  output logic              dqs_oe_o
);
  // per-bit edge select: high phase carries low half
  for (genvar b = 0; b < DQ_W; b++) begin : g_bit
    assign dq_o[b] = data_i & (clk_i ? word_i[b] : word_i[DQ_W + b]);
  end

  // data_i changes at clk rise while clk90 is low: gate is glitch free
  assign dqs_o    = data_i & clk90_i;
  assign dq_oe_o  = pre_i | data_i;
  assign dqs_oe_o = pre_i | data_i;
endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture #(
  parameter int unsigned DQ_W  = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned WORD_W = 2 * DQ_W,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic              dqs_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DQ_W-1:0]   lo_q;
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wp_q, wp_gray_q;
  logic [PW-1:0]     sync1_q, sync2_q;
  logic [PW-1:0]     rp_q;
  logic [PW-1:0]     wp_core;
  logic [PW-1:0]     wp_next;

  // strobe domain: rising beat held, falling beat completes the word
  always_ff @(posedge dqs_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else         lo_q <= dq_i;
  end

  assign wp_next = wp_q + 1'b1;

  always_ff @(negedge dqs_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q      <= '0;
      wp_gray_q <= '0;
    end else begin
      wp_q      <= wp_next;
      wp_gray_q <= wp_next ^ (wp_next >> 1);
    end
  end

  always_ff @(negedge dqs_i) begin
    mem_q[wp_q[AW-1:0]] <= {dq_i, lo_q};
  end

  // core domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= wp_gray_q;
      sync2_q <= sync1_q;
    end
  end

  assign wp_core = gray2bin(sync2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q       <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else if (rp_q != wp_core) begin
      rd_data_o  <= mem_q[rp_q[AW-1:0]];
      rd_valid_o <= 1'b1;
      rp_q       <= rp_q + 1'b1;
    end else begin
      rd_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_strobe_path.sv
module ddr_strobe_path #(
  parameter int unsigned DQ_W     = 8,
  parameter int unsigned RD_DEPTH = 4,
  localparam int unsigned WORD_W = 2 * DQ_W
) (
  input  logic              clk_i,
  input  logic              clk90_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic [1:0]        wr_bl_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_take_o,
  output logic              wr_busy_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              dqs_o,
  output logic              dqs_oe_o,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic              dqs_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [WORD_W-1:0] word;
  logic              in_pre, in_data;

  ddr_wr_seq #(.DQ_W(DQ_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wr_start_i),
    .bl_i   (wr_bl_i),
    .data_i (wr_data_i),
    .word_o (word),
    .pre_o  (in_pre),
    .data_o (in_data),
    .take_o (wr_take_o),
    .busy_o (wr_busy_o)
  );

  ddr_tx_mux #(.DQ_W(DQ_W)) u_tx (
    .clk_i   (clk_i),
    .clk90_i (clk90_i),
    .word_i  (word),
    .pre_i   (in_pre),
    .data_i  (in_data),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o),
    .dqs_o   (dqs_o),
    .dqs_oe_o(dqs_oe_o)
  );

  ddr_rd_capture #(.DQ_W(DQ_W), .DEPTH(RD_DEPTH)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dq_i      (dq_i),
    .dqs_i     (dqs_i),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o)
  );
endmodule

// File: rtl/ddr_strobe_path_chk.sv
module ddr_strobe_path_chk
  import ddr_path_pkg::*;
#(
  parameter int unsigned DQ_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_start_i,
  input logic [1:0]          wr_bl_i,
  input logic                wr_take_o,
  input logic                wr_busy_o,
  input logic                dq_oe_o,
  input logic                dqs_oe_o,
  input logic                rd_valid_o,
  input logic [2*DQ_W-1:0]   rd_data_o
);
  logic [2:0] exp_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      cnt_q <= '0;
    end else if (wr_start_i && !wr_busy_o) begin
      exp_q <= burst_words(wr_bl_i);
      cnt_q <= '0;
    end else if (wr_take_o) begin
      cnt_q <= cnt_q + 3'd1;
    end
  end

  // R2: words sampled over a burst match the length code given at start
  a_r2_word_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_busy_o) |-> cnt_q == exp_q);

  // R3: a burst opens with the pins driven and a word requested
  a_r3_preamble_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_busy_o) |-> wr_take_o && dq_oe_o && dqs_oe_o);

  // R6: pins released when the burst ends
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_busy_o) |-> !dq_oe_o && !dqs_oe_o);

  // R7: a burst only begins from a start request
  a_r7_start_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_busy_o) |-> $past(wr_start_i));

  // R2: no word requested outside a burst
  a_r2_take_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take_o |-> wr_busy_o);

  // R8: a delivered word is fully defined
  a_r8_valid_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !$isunknown(rd_data_o));
endmodule

bind ddr_strobe_path ddr_strobe_path_chk #(.DQ_W(DQ_W)) u_chk (.*);

// File: tb/sim_ddr_strobe_path.sv
`timescale 1ns/1ps
module sim_ddr_strobe_path;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk_i = 1'b0, clk90_i = 1'b0, rst_ni = 1'b0;
  logic wr_start_i = 1'b0;
  logic [1:0] wr_bl_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic wr_take_o, wr_busy_o, dq_oe_o, dqs_o, dqs_oe_o, rd_valid_o;
  logic [N-1:0] dq_o;
  logic [N-1:0] dq_i = '0;
  logic dqs_i = 1'b0;
  logic [W-1:0] rd_data_o;

  int n_run = 0, n_fail = 0;
  int n_exp = 0, n_got = 0;
  logic [W-1:0] exp_rd [512];
  bit done = 0;

  always #4 clk_i = ~clk_i;
  initial begin
    #2;
    forever #4 clk90_i = ~clk90_i;
  end

  ddr_strobe_path #(.DQ_W(N)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int words_of(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // read collector: R8/R9 ordering and content
  always @(posedge clk_i) begin
    #1;
    if (rd_valid_o) begin
      chk("R8 read word", 32'(rd_data_o), 32'(exp_rd[n_got % 512]));
      n_got++;
    end
  end

  task automatic do_write(input logic [1:0] bl, input bit poke);
    int nw;
    logic [W-1:0] w [4];
    nw = words_of(bl);
    for (int i = 0; i < 4; i++) w[i] = W'($urandom);
    @(negedge clk_i);
    wr_start_i = 1'b1;
    wr_bl_i    = bl;
    @(posedge clk_i); #1;
    // preamble cycle
    wr_start_i = poke;
    if (poke) wr_bl_i = ~bl;
    chk("R3 dq_oe", 32'(dq_oe_o), 1);
    chk("R3 dqs_oe", 32'(dqs_oe_o), 1);
    chk("R3 take", 32'(wr_take_o), 1);
    chk("R3 dqs low", 32'(dqs_o), 0);
    chk("R3 dq zero", 32'(dq_o), 0);
    wr_data_i = w[0];
    #4;
    chk("R3 dqs low late", 32'(dqs_o), 0);
    for (int k = 0; k < nw; k++) begin
      @(posedge clk_i); #1;
      if (k == nw - 1) wr_start_i = 1'b0;
      chk("R4 low half", 32'(dq_o), 32'(w[k][N-1:0]));
      chk("R5 dqs before centre", 32'(dqs_o), 0);
      chk(poke ? "R7 take" : "R2 take", 32'(wr_take_o), (k < nw - 1) ? 1 : 0);
      if (k < nw - 1) wr_data_i = w[k+1];
      #2;
      chk("R5 dqs high", 32'(dqs_o), 1);
      #2;
      chk("R4 high half", 32'(dq_o), 32'(w[k][W-1:N]));
      #2;
      chk("R5 dqs low", 32'(dqs_o), 0);
    end
    @(posedge clk_i); #1;
    chk(poke ? "R7 release" : "R6 dq_oe", 32'(dq_oe_o), 0);
    chk("R6 dqs_oe", 32'(dqs_oe_o), 0);
    chk("R6 busy", 32'(wr_busy_o), 0);
    @(posedge clk_i); #1;
    chk("R7 no restart", 32'(wr_busy_o), 0);
  endtask

  task automatic do_read(input int nw, input logic [W-1:0] fixed, input bit use_fixed);
    logic [W-1:0] w;
    int base;
    base = n_exp;
    @(posedge clk_i); #1;
    for (int i = 0; i < nw; i++) begin
      w = use_fixed ? fixed : W'($urandom);
      exp_rd[n_exp % 512] = w;
      n_exp++;
      dq_i = w[N-1:0];
      #1 dqs_i = 1'b1;
      #3 dq_i = w[W-1:N];
      #1 dqs_i = 1'b0;
      #3;
    end
    repeat (8) @(posedge clk_i);
    #2;
    chk("R9 words delivered", 32'(n_got), 32'(base + nw));
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 dq_oe", 32'(dq_oe_o), 0);
    chk("R1 dqs_oe", 32'(dqs_oe_o), 0);
    chk("R1 rd_valid", 32'(rd_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 busy", 32'(wr_busy_o), 0);
    chk("R1 take", 32'(wr_take_o), 0);
    chk("R1 dq", 32'(dq_o), 0);
    chk("R1 dqs", 32'(dqs_o), 0);
    void'($urandom(32'h5eed_1234));
    // directed: every length code
    do_write(2'b00, 0);
    do_write(2'b01, 0);
    do_write(2'b10, 0);
    do_write(2'b11, 0);
    // R7: start held through the burst with another length
    do_write(2'b00, 1);
    do_write(2'b10, 1);
    // directed reads: one word, alternating patterns, full stream
    do_read(1, 16'hA55A, 1);
    do_read(2, 16'hFF00, 1);
    do_read(8, '0, 0);
    // random mix
    for (int i = 0; i < 30; i++) begin
      if ($urandom_range(0, 1) == 0) do_write(2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
      else do_read($urandom_range(1, 8), '0, 0);
    end
    chk("R9 total", 32'(n_got), 32'(n_exp));
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule